// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank with Coherent Count Capture

This block holds four independent 16-bit down-counters behind a byte-wide register port. Each counter advances on one of four single-cycle tick pulses supplied by the surrounding logic, picked per channel by a two-bit selector. When a counter has reached zero, its next selected tick reloads it from its load register and raises a sticky interrupt flag. An interrupt enable gates that flag onto the channel's interrupt line. A shared enable register turns each channel on or off. The same register also holds a capture-mode bit that decides how live counts are frozen for reading.

A 16-bit count is read as two bytes. Without some care, the low and high halves could come from different moments. To prevent this, reading a channel's low byte copies the live count into a per-channel holding register, and the high byte always comes from that holding register. In per-channel capture mode, every low-byte read refreshes only its own channel. In group capture mode, only channel 1's low-byte read captures anything, and it freezes all four channels in the same clock. The other channels can then be read in any order without disturbing the frozen snapshot.

Software sees these local byte offsets, all 5 bits wide:
- Load registers: 0x00 to 0x07, with channel n (n = 0..3) at 2n for the low byte and 2n+1 for the high byte.
- Count registers: channel 1 at 0x08/0x09, channel 2 at 0x0A/0x0B, channel 3 at 0x10/0x11, channel 4 at 0x12/0x13.
- Shared enable register: 0x0C.
- Control/status registers: channels 1 to 4 at 0x14 to 0x17.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register reads 0, every irq line is low, and every channel's counter and load value are 0.
- R2: Enable register bits 0..3 switch channels 1..4 on (1) or off (0), each independently. A channel that is off keeps its count unchanged whatever its tick does.
- R3: An enabled channel with a non-zero count decrements by one on each cycle its selected tick is high. Control bits 2:1 pick the tick: 00, 01, 10 and 11 select tick_i[0], [1], [2] and [3]. Pulses on the other tick inputs have no effect.
- R4: When an enabled channel's count is 0, its next selected tick reloads the count from the load register and sets the channel's flag (control bit 7).
- R5: Writing a control register with bit 7 = 1 clears the flag, and bit 7 = 0 leaves it unchanged. If a reload happens in the same cycle as a clear, the flag stays set. Once set, the flag stays set until it is cleared.
- R6: irq_o[n] is high exactly when channel n's flag and its interrupt enable (control bit 0) are both 1.
- R7: A write to either load byte of a channel that is off also copies the whole new load value into its counter. The same write to a channel that is on leaves the counter untouched.
- R8: With the capture-mode bit (enable bit 4) at 0, a low-byte count read freezes only that channel's count and returns its low byte. A high-byte read returns the high byte of the frozen value.
- R9: With the capture-mode bit at 1, a read of channel 1's count low byte freezes all four channels in one cycle. Low-byte reads of channels 2..4 return frozen values and do not re-freeze.
- R10: With control bit 3 set, both count bytes of that channel return the load value instead of the frozen count. Capture still happens as usual.
- R11: Enable bits 7:5 and control bits 6:4 are stored and read back. Unmapped offsets read 0.
- R12: Read data appears on bus_rdata in the cycle after the bus_rd cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 4 | Single-cycle tick pulses, selectable per channel |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 5 | Local byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 4 | Per-channel interrupt, flag gated by enable |

## Verification
The properties assume that tick_i carries clock-synchronous pulses that are sampled once per edge, and that bus_rd and bus_wr are never high together. They also assume a counter changes only through a tick, a reload or a load write to an idle channel. The stimulus pulses ticks only between register accesses and issues each access as a lone one-cycle strobe. This keeps counts stable while the expected bytes are worked out. Group-capture checks deliberately tick the channels after the snapshot, so that frozen and live values differ and a wrong re-freeze would show up in the returned byte.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

  localparam int unsigned NUM_CH   = 4;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned SEL_W    = 2;

  localparam logic [ADDR_W-1:0] OFF_LOAD_BASE = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_ENABLE    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTRL_BASE = 5'h14;

  localparam int unsigned EN_GROUP_BIT = 4;

  // control byte without the flag, which lives in the channel
  typedef struct packed {
    logic [2:0]       spare;
    logic             show_load;
    logic [SEL_W-1:0] tick_sel;
    logic             irq_en;
  } ctrl_t;

  // count register placement: channels 1,2 below the enable byte, 3,4 above
  function automatic logic [ADDR_W-1:0] cnt_off(input int unsigned ch);
    if (ch < 2) return ADDR_W'(8 + 2 * ch);
    else        return ADDR_W'(12 + 2 * ch);
  endfunction

endpackage

// File: rtl/ttb_rst_sync.sv
module ttb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/ttb_channel.sv
module ttb_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             ld_wr_lo,
  input  logic             ld_wr_hi,
  input  logic [7:0]       wbyte,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);

  localparam int unsigned HI_W = CNT_W - 8;

  logic [CNT_W-1:0] load_d;
  logic [CNT_W-1:0] cnt_d;
  logic             flag_d;
  logic             wrap;
  logic             step;

  assign step = run_en && tick;
  assign wrap = step && (cnt_q == '0);

  always_comb begin
    load_d = load_q;
    if (ld_wr_lo) load_d[7:0]       = wbyte;
    if (ld_wr_hi) load_d[CNT_W-1:8] = wbyte[HI_W-1:0];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run_en && (ld_wr_lo || ld_wr_hi)) cnt_d = load_d;
    else if (wrap)                         cnt_d = load_q;
    else if (step)                         cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (wrap)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      load_q <= load_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tick_i,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [3:0] irq_o
);
  import ttb_pkg::*;

  localparam int unsigned HI_W = CNT_W - 8;

  logic rst_s_n;

  logic [7:0]        en_q, en_d;
  ctrl_t             ctrl_q [NUM_CH];
  ctrl_t             ctrl_d [NUM_CH];
  logic [CNT_W-1:0]  hold_q [NUM_CH];
  logic [CNT_W-1:0]  hold_d [NUM_CH];
  logic [7:0]        rdata_q, rdata_d;

  logic [CNT_W-1:0]  load_w [NUM_CH];
  logic [CNT_W-1:0]  cnt_w  [NUM_CH];
  logic [NUM_CH-1:0] flag_w;
  logic [NUM_CH-1:0] run_en;
  logic [NUM_CH-1:0] tick_hit;
  logic [NUM_CH-1:0] ld_lo_wr, ld_hi_wr, ld_touch;
  logic [NUM_CH-1:0] ctrl_wr, flag_clr;
  logic [NUM_CH-1:0] cnt_lo_rd;
  logic [NUM_CH-1:0] irq_en;
  logic              group_mode;

  logic [NUM_CH*CNT_W-1:0] cnt_flat, load_flat, hold_flat;

  ttb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s_n(rst_s_n)
  );

  assign group_mode = en_q[EN_GROUP_BIT];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign run_en[g]    = en_q[g];
    assign irq_en[g]    = ctrl_q[g].irq_en;
    assign tick_hit[g]  = tick_i[ctrl_q[g].tick_sel];
    assign ld_lo_wr[g]  = bus_wr && (bus_addr == OFF_LOAD_BASE + ADDR_W'(2 * g));
    assign ld_hi_wr[g]  = bus_wr && (bus_addr == OFF_LOAD_BASE + ADDR_W'(2 * g + 1));
    assign ld_touch[g]  = ld_lo_wr[g] || ld_hi_wr[g];
    assign ctrl_wr[g]   = bus_wr && (bus_addr == OFF_CTRL_BASE + ADDR_W'(g));
    assign flag_clr[g]  = ctrl_wr[g] && bus_wdata[7];
    assign cnt_lo_rd[g] = bus_rd && (bus_addr == cnt_off(g));

    ttb_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .run_en  (run_en[g]),
      .tick    (tick_hit[g]),
      .ld_wr_lo(ld_lo_wr[g]),
      .ld_wr_hi(ld_hi_wr[g]),
      .wbyte   (bus_wdata),
      .flag_clr(flag_clr[g]),
      .load_q  (load_w[g]),
      .cnt_q   (cnt_w[g]),
      .flag_q  (flag_w[g])
    );

    assign irq_o[g] = flag_w[g] && ctrl_q[g].irq_en;

    assign cnt_flat [g*CNT_W +: CNT_W] = cnt_w[g];
    assign load_flat[g*CNT_W +: CNT_W] = load_w[g];
    assign hold_flat[g*CNT_W +: CNT_W] = hold_q[g];
  end

  // shared enable and control registers
  always_comb begin
    en_d = en_q;
    if (bus_wr && (bus_addr == OFF_ENABLE)) en_d = bus_wdata;
    for (int i = 0; i < NUM_CH; i++) begin
      ctrl_d[i] = ctrl_q[i];
      if (ctrl_wr[i]) ctrl_d[i] = ctrl_t'(bus_wdata[6:0]);
    end
  end

  // capture of live counts into the holding registers
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      hold_d[i] = hold_q[i];
      if (group_mode) begin
        if (cnt_lo_rd[0]) hold_d[i] = cnt_w[i];
      end else begin
        if (cnt_lo_rd[i]) hold_d[i] = cnt_w[i];
      end
    end
  end

  // read mux, registered one cycle after the strobe
  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      if (bus_addr == OFF_ENABLE) rdata_d = en_q;
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr == OFF_LOAD_BASE + ADDR_W'(2 * i))
          rdata_d = load_w[i][7:0];
        if (bus_addr == OFF_LOAD_BASE + ADDR_W'(2 * i + 1))
          rdata_d = 8'(load_w[i][CNT_W-1:8]);
        if (bus_addr == OFF_CTRL_BASE + ADDR_W'(i))
          rdata_d = {flag_w[i], ctrl_q[i]};
        if (bus_addr == cnt_off(i))
          rdata_d = ctrl_q[i].show_load ? load_w[i][7:0] : hold_d[i][7:0];
        if (bus_addr == cnt_off(i) + ADDR_W'(1))
          rdata_d = ctrl_q[i].show_load ? 8'(load_w[i][CNT_W-1:8])
                                        : 8'(hold_q[i][CNT_W-1:8]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q    <= '0;
      rdata_q <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        ctrl_q[i] <= '0;
        hold_q[i] <= '0;
      end
    end else begin
      en_q    <= en_d;
      rdata_q <= rdata_d;
      for (int i = 0; i < NUM_CH; i++) begin
        ctrl_q[i] <= ctrl_d[i];
        hold_q[i] <= hold_d[i];
      end
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       run_en,
  input logic                    group_mode,
  input logic [NUM_CH-1:0]       tick_hit,
  input logic [NUM_CH-1:0]       ld_touch,
  input logic [NUM_CH-1:0]       flag_clr,
  input logic [NUM_CH-1:0]       flag,
  input logic [NUM_CH-1:0]       irq_en,
  input logic [NUM_CH-1:0]       irq,
  input logic                    bus_rd,
  input logic                    bus_wr,
  input logic [4:0]              bus_addr,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat,
  input logic [NUM_CH*CNT_W-1:0] load_flat,
  input logic [NUM_CH*CNT_W-1:0] hold_flat
);
  import ttb_pkg::*;

  // bus usage assumed by the properties below
  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en[g] && !ld_touch[g]) |=> cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en[g] && tick_hit[g] && cnt_flat[g*CNT_W +: CNT_W] != '0)
      |=> cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) - CNT_W'(1));

    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en[g] && tick_hit[g] && cnt_flat[g*CNT_W +: CNT_W] == '0)
      |=> (cnt_flat[g*CNT_W +: CNT_W] == $past(load_flat[g*CNT_W +: CNT_W])) && flag[g]);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !flag_clr[g]) |=> flag[g]);

    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en[g]) |-> !irq[g]);

    if (g > 0) begin : g_grp
      a_r9_no_relatch: assert property (@(posedge clk) disable iff (!rst_n)
        (group_mode && bus_rd && bus_addr == cnt_off(g))
        |=> hold_flat[g*CNT_W +: CNT_W] == $past(hold_flat[g*CNT_W +: CNT_W]));
    end
  end

endmodule

bind tick_timer_bank ttb_checker #(.CNT_W(CNT_W), .NUM_CH(ttb_pkg::NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .run_en    (run_en),
  .group_mode(group_mode),
  .tick_hit  (tick_hit),
  .ld_touch  (ld_touch),
  .flag_clr  (flag_clr),
  .flag      (flag_w),
  .irq_en    (irq_en),
  .irq       (irq_o),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cnt_flat  (cnt_flat),
  .load_flat (load_flat),
  .hold_flat (hold_flat)
);

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;

  logic       clk;
  logic       rst_n;
  logic [3:0] tick_i;
  logic       bus_rd;
  logic       bus_wr;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [3:0] irq_o;

  int n_tests;
  int n_fail;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic     rd_d;

  tick_timer_bank u_tick_timer_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: compares the registered read byte against the queued expectation
  always @(negedge clk) begin
    if (rd_d) begin
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read with no expectation, got %02h", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %02h expected %02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    tick_i = m;
    repeat (n) @(negedge clk);
    tick_i = '0;
  endtask

  task automatic chk_irq(input logic [3:0] e, input string tag);
    n_tests++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq got %b expected %b", tag, irq_o, e);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_tests = 0; n_fail = 0;
    tick_i = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_irq(4'b0000, "R1 irq after reset");
    rd(5'h0C, 8'h00, "R1 enable reset");
    rd(5'h14, 8'h00, "R1 control reset");
    rd(5'h08, 8'h00, "R1 count reset");
    rd(5'h00, 8'h00, "R1 load reset");

    // R7 loads while idle copy into counters
    wr(5'h00, 8'h34); wr(5'h01, 8'h12);
    wr(5'h02, 8'h05); wr(5'h03, 8'h00);
    wr(5'h04, 8'h00); wr(5'h05, 8'h01);
    wr(5'h06, 8'h00); wr(5'h07, 8'h02);
    rd(5'h08, 8'h34, "R7 idle load copied lo");
    rd(5'h09, 8'h12, "R7 idle load copied hi");

    // R3 tick select 01 on channel 1, R2 channel 2 off
    wr(5'h14, 8'h02);
    wr(5'h0C, 8'h01);
    pulse(4'b0001, 3);
    rd(5'h08, 8'h34, "R3 unselected tick ignored");
    pulse(4'b0010, 4);
    rd(5'h08, 8'h30, "R3 four selected ticks lo");
    rd(5'h09, 8'h12, "R3 four selected ticks hi");
    rd(5'h0A, 8'h05, "R2 disabled channel holds");

    // R4 R5 R6 on channel 2, tick 0
    wr(5'h15, 8'h01);
    wr(5'h0C, 8'h03);
    pulse(4'b0001, 5);
    rd(5'h0A, 8'h00, "R4 counted to zero");
    chk_irq(4'b0000, "R4 no flag at zero");
    pulse(4'b0001, 1);
    rd(5'h0A, 8'h05, "R4 reload after zero");
    rd(5'h15, 8'h81, "R4 flag set");
    chk_irq(4'b0010, "R6 irq flag and enable");
    wr(5'h15, 8'h01);
    rd(5'h15, 8'h81, "R5 write 0 keeps flag");
    wr(5'h15, 8'h80);
    rd(5'h15, 8'h00, "R5 write 1 clears flag");
    chk_irq(4'b0000, "R6 irq low after clear");
    pulse(4'b0001, 6);
    rd(5'h15, 8'h80, "R4 flag set again");
    chk_irq(4'b0000, "R6 irq masked by enable");
    wr(5'h15, 8'h01);
    chk_irq(4'b0010, "R6 irq on enable");

    // R7 load write while running leaves counter
    wr(5'h02, 8'h09);
    rd(5'h0A, 8'h05, "R7 running load write ignored");

    // R10 show load value
    wr(5'h14, 8'h0A);
    rd(5'h08, 8'h34, "R10 load lo shown");
    rd(5'h09, 8'h12, "R10 load hi shown");
    wr(5'h14, 8'h02);

    // R8 per-channel capture
    wr(5'h0C, 8'h02);
    wr(5'h00, 8'h00); wr(5'h01, 8'h01);
    rd(5'h08, 8'h00, "R8 capture lo");
    wr(5'h0C, 8'h03);
    pulse(4'b0010, 1);
    rd(5'h09, 8'h01, "R8 hi from held value");
    rd(5'h08, 8'hFF, "R8 recapture lo");
    rd(5'h09, 8'h00, "R8 hi after recapture");

    // R9 group capture
    wr(5'h0C, 8'h1F);
    rd(5'h08, 8'hFF, "R9 snapshot via channel 1");
    pulse(4'b0001, 2);
    rd(5'h0A, 8'h05, "R9 ch2 held");
    rd(5'h12, 8'h00, "R9 ch4 held lo");
    rd(5'h13, 8'h02, "R9 ch4 held hi");
    rd(5'h11, 8'h01, "R9 ch3 held hi");
    rd(5'h10, 8'h00, "R9 ch3 held lo");
    rd(5'h0A, 8'h05, "R9 ch2 no relatch");
    rd(5'h08, 8'hFF, "R9 second snapshot");
    rd(5'h0A, 8'h03, "R9 ch2 new snapshot");
    rd(5'h10, 8'hFE, "R9 ch3 new snapshot");

    // R11 spare bits and unmapped offsets
    wr(5'h0C, 8'hFF);
    rd(5'h0C, 8'hFF, "R11 enable spare bits");
    wr(5'h16, 8'h7F);
    rd(5'h16, 8'h7F, "R11 control spare bits");
    rd(5'h07, 8'h02, "R11 load ch4 hi");
    rd(5'h1A, 8'h00, "R11 unmapped reads zero");

    // R12 data holds after the read cycle
    repeat (2) @(negedge clk);
    n_tests++;
    if (bus_rdata !== 8'h00) begin
      n_fail++;
      $display("FAIL R12 hold: got %02h expected %02h", bus_rdata, 8'h00);
    end

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule